// File: doc/BRIEF.md
# Gated Burst Serial Clock Generator

This block emits a finite train of serial clock pulses. One start strobe sets the train length. The length is a number of words times a number of bits per word. Each pulse takes three system clock cycles: the clock is high for two cycles and then low for one.

The train is produced by two counters. The first is a one-shot word window. Its prescaler lasts one word's worth of pulse periods, and each time the prescaler wraps, the word counter advances. The window closes by itself after the last word. The second counter is a phase divider. It runs only while the window is open and holds its phase when the window is closed.

When a start is accepted, the block clears the prescaler, the word counter and the divider phase in the same cycle. Because of this, every burst begins at a known phase and holds exactly the requested number of pulses. A busy flag covers the burst, and a single-cycle done pulse marks its end.

Top module: `burst_sclk_gen`

## Requirements
- R1: After reset, sclk_o, busy_o and done_o are all low.
- R2: If start_i is high on a clock edge while busy_o is low and words_i is nonzero, busy_o is high from the next cycle. It stays high for exactly words × bpw × 3 cycles.
- R3: While busy_o is high, sclk_o repeats a three-cycle pattern of high, high, low. The first high falls in the first busy cycle.
- R4: The number of low-to-high transitions of sclk_o in one burst equals words × bpw.
- R5: done_o is high for exactly one cycle. That cycle is the first cycle after busy_o falls.
- R6: A start with words_i equal to zero gives no busy cycle and no pulse. done_o is high in the cycle after the start.
- R7: A start_i strobe that arrives while busy_o is high is ignored. The running burst keeps its length and its pulse count.
- R8: bpw_i is taken at start and applies to the whole burst. Values from 6 to 19 are used as given. Values below 6 act as 6, and values above 19 act as 19.
- R9: sclk_o is low whenever busy_o is low.
- R10: A start accepted in the done cycle of the previous burst gives a complete new burst. Pulses and length follow R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start strobe |
| words_i | input | WORDS_W | Number of words in the burst |
| bpw_i | input | BPW_W | Bits (pulses) per word, clamped to 6..19 |
| sclk_o | output | 1 | Gated serial clock |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
A stale prescaler or word counter left over from the previous burst would change the length of busy_o. That error shows up when the burst ends, as a wrong cycle count and a wrong number of sclk_o edges. A divider phase that is not cleared would break the high-high-low pattern within the first three busy cycles. Each cycle of every burst is compared with the arithmetic pattern. The sweep covers every bits-per-word value in range and just outside it, and several short word counts. It also runs back-to-back starts and a long burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned PULSE_PERIOD = 3;
  localparam int unsigned PULSE_HIGH   = 2;
  localparam int unsigned BPW_MIN      = 6;
  localparam int unsigned BPW_MAX      = 19;
endpackage

// File: rtl/burst_window.sv
module burst_window #(
  parameter int unsigned WORDS_W = 15,
  parameter int unsigned PRE_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [WORDS_W-1:0] words_i,
  input  logic [PRE_W-1:0]   word_len_i,
  output logic               busy_o,
  output logic               done_o
);
  logic [WORDS_W-1:0] words_q, wcnt_q;
  logic [PRE_W-1:0]   len_q, pre_q;
  logic               busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
      wcnt_q  <= '0;
      len_q   <= '0;
      pre_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        // all phase state cleared at start
        pre_q   <= '0;
        wcnt_q  <= '0;
        words_q <= words_i;
        len_q   <= word_len_i;
        if (words_i == '0) done_q <= 1'b1;
        else               busy_q <= 1'b1;
      end else if (busy_q) begin
        if (pre_q == len_q - 1'b1) begin
          pre_q <= '0;
          if (wcnt_q == words_q - 1'b1) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  p_pre_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> pre_q < len_q);
  p_word_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> wcnt_q < words_q);
  p_done_after_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_q);
  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
endmodule

// File: rtl/pulse_divider.sv
module pulse_divider #(
  parameter int unsigned PERIOD = 3,
  parameter int unsigned HIGH   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic gate_i,
  output logic sclk_o
);
  localparam int unsigned PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HIGH);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph_q <= '0;
    else if (clear_i)      ph_q <= '0;
    else if (gate_i)       ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end

  assign sclk_o = gate_i && (ph_q < PH_HIGH);

  p_phase_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !clear_i && ph_q == PH_LAST) |=> ph_q == '0);
  p_phase_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !clear_i) |=> $stable(ph_q));
  p_phase_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= PH_LAST);
endmodule

// File: rtl/burst_sclk_gen.sv
module burst_sclk_gen
  import burst_pkg::*;
#(
  parameter int unsigned WORDS_W = 15,
  parameter int unsigned BPW_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WORDS_W-1:0] words_i,
  input  logic [BPW_W-1:0]   bpw_i,
  output logic               sclk_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned PRE_W = $clog2(PULSE_PERIOD * BPW_MAX + 1);

  logic             load;
  logic [PRE_W-1:0] bpw_eff, word_len;

  assign load = start_i && !busy_o;

  always_comb begin
    if (bpw_i < BPW_W'(BPW_MIN))      bpw_eff = PRE_W'(BPW_MIN);
    else if (bpw_i > BPW_W'(BPW_MAX)) bpw_eff = PRE_W'(BPW_MAX);
    else                              bpw_eff = PRE_W'(bpw_i);
    word_len = bpw_eff * PRE_W'(PULSE_PERIOD);
  end

  burst_window #(.WORDS_W(WORDS_W), .PRE_W(PRE_W)) u_window (
    .clk_i, .rst_ni,
    .load_i(load), .words_i, .word_len_i(word_len),
    .busy_o, .done_o
  );

  pulse_divider #(.PERIOD(PULSE_PERIOD), .HIGH(PULSE_HIGH)) u_div (
    .clk_i, .rst_ni,
    .clear_i(load), .gate_i(busy_o), .sclk_o
  );

  p_sclk_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  p_start_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && words_i != '0) |=> busy_o && sclk_o);
  p_zero_words_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && words_i == '0) |=> done_o && !busy_o);
endmodule

// File: tb/burst_sclk_gen_test.sv
module burst_sclk_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] words_i = '0;
  logic [4:0]  bpw_i = 5'd16;
  logic        sclk_o, busy_o, done_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  burst_sclk_gen uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_bpw(input int b);
    return (b < 6) ? 6 : (b > 19) ? 19 : b;
  endfunction

  // drive at negedge; the following negedge is the first post-start cycle
  task automatic burst(input int words, input int bpw, input bit poke);
    int exp_len, len, edges;
    bit prev;
    exp_len = words * eff_bpw(bpw) * 3;
    words_i = 15'(words);
    bpw_i   = 5'(bpw);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (words == 0) begin
      check(!busy_o, "R6", busy_o, 0);
      check(done_o && !sclk_o, "R6", done_o, 1);
      @(negedge clk_i);
      check(!done_o, "R5", done_o, 0);
      return;
    end
    check(busy_o, "R2", busy_o, 1);
    check(!done_o, "R5", done_o, 0);
    len = 0; edges = 0; prev = 1'b0;
    while (busy_o) begin
      check(sclk_o == ((len % 3) < 2), "R3", sclk_o, (len % 3) < 2);
      if (sclk_o && !prev) edges++;
      prev = sclk_o;
      len++;
      if (poke && len == 4) begin
        words_i = 15'(words + 7);
        bpw_i   = 5'd6;
        start_i = 1'b1;
      end
      @(negedge clk_i);
      start_i = 1'b0;
    end
    check(len == exp_len, poke ? "R7" : "R2/R8", len, exp_len);
    check(edges == words * eff_bpw(bpw), "R4", edges, words * eff_bpw(bpw));
    check(done_o, "R5", done_o, 1);
    check(!sclk_o, "R9", sclk_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!sclk_o && !busy_o && !done_o, "R1", {sclk_o, busy_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!sclk_o && !busy_o && !done_o, "R1", {sclk_o, busy_o, done_o}, 0);

    // sweep bpw across and beyond range (R8), short word counts
    for (int b = 4; b <= 21; b++) begin
      for (int w = 0; w <= 4; w++) begin
        burst(w, b, 1'b0);
        @(negedge clk_i);
        check(!done_o && !sclk_o, "R5", done_o, 0);
      end
    end

    // start ignored while busy (R7)
    burst(5, 16, 1'b1);
    @(negedge clk_i);

    // back-to-back, start taken in done cycle (R10)
    burst(3, 7, 1'b0);
    burst(2, 19, 1'b0);
    burst(1, 6, 1'b0);
    burst(0, 9, 1'b0);
    @(negedge clk_i);
    check(!busy_o && !sclk_o, "R10", busy_o, 0);

    // long burst
    burst(1000, 19, 1'b0);
    @(negedge clk_i);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    while (cycles < WATCHDOG) begin
      @(posedge clk_i);
      cycles++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule